// File: doc/BRIEF.md
# Vectored CPU Interrupt Unit

This unit sits beside a processor core and decides when the core must leave its instruction stream to service an external interrupt. It has thirty-two level-sensitive request lines. A line that is seen high latches a sticky bit in a pending register. That bit stays set after the line falls, until software clears it. A mask register selects which pending bits may interrupt the core. A two-bit enable register holds a live global enable and a saved copy of it.

The core pulses a strobe each time it finishes an instruction and presents its program counter at the same time. At such a boundary the unit checks three things: the live enable is set, some pending bit is also set in the mask, and the strobe is present. If all three hold, then on the next clock the unit does three things:
- it asks the core to write the current program counter into general register 30;
- it hands the core a new program counter, which is the exception base address plus a fixed slot offset (interrupt identifier times 32);
- it writes the enable register to 0x2, which stores the old enable in the saved bit and turns interrupts off.

A return-from-exception strobe copies the saved bit back into the live bit. While a request line stays high, its pending bit is set again after each clear. The same request is therefore taken again as soon as interrupts are re-enabled.

Top module: `cpu_irq_unit`

## Requirements
- R1: After synchronous reset, the pending, mask and enable registers read 0, and no redirect is requested.
- R2: A request line n that is 1 at a clock edge sets pending bit n, and a CSR read shows it right after that edge.
- R3: A pending bit stays set after its request line returns to 0.
- R4: A CSR write to pending (select 0) clears every bit written as 1 and leaves the others. If a line is still held high, its bit is set again at the following edge.
- R5: No redirect follows a boundary strobe in any of these cases: enable bit 0 is 0, the AND of mask and pending is zero, or the strobe is absent.
- R6: When a boundary strobe meets enable bit 0 set and a non-zero mask-and-pending, the next edge raises `pc_load` and `ret_we` for exactly one cycle. In that cycle `ret_reg` is 30, `ret_value` is the program counter sampled at the strobe, and `pc_target` is the base plus EXC_ID*32 (base + 0xC0 by default).
- R7: Taking an interrupt leaves the enable register (select 2) reading 0x2.
- R8: A return-from-exception strobe copies enable bit 1 into bit 0 and keeps bit 1.
- R9: The exception base register (select 3) ignores the low 8 bits of a write and reads them back as 0.
- R10: A line held high is taken again at the first boundary after software sets enable bit 0 again.
- R11: The mask register (select 1) stores and reads back all 32 bits of a write.
- R12: If a take and a return-from-exception occur in the same cycle, the take wins and enable reads 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level interrupt request lines, bit n is line n |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 2 | CSR select: 0 pending, 1 mask, 2 enable, 3 base |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for csr_addr (combinational) |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| cur_pc | input | 32 | Core program counter at the boundary |
| eret | input | 1 | Return-from-exception strobe |
| ret_we | output | 1 | Request to write the return address to a register |
| ret_reg | output | 5 | Index of the register for the return address (30) |
| ret_value | output | 32 | Return address to write |
| pc_load | output | 1 | Request to load a new program counter |
| pc_target | output | 32 | Handler address to load |

## Verification
A request line shows up in pending one edge after it is driven high. The redirect outputs appear one edge after the boundary strobe and last a single cycle. The enable register reads 0x2 right after that same edge. The bench drives inputs just after a rising edge and reads CSRs once the combinational read has settled. Each time it drives a boundary that should take, it queues the expected return address and handler address. A monitor checks `pc_load` at every falling edge, so each redirect is compared one cycle after its strobe, and a redirect that was not queued counts as a failure.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;

    localparam int XLEN_DEF  = 32;
    localparam int LINES_DEF = 32;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_ENAB = 2'd2,
        SEL_BASE = 2'd3
    } csr_sel_e;

    // bit 1 = saved copy, bit 0 = live global enable
    typedef struct packed {
        logic saved;
        logic live;
    } irq_en_t;

    function automatic logic [XLEN_DEF-1:0] slot_addr(
        input logic [XLEN_DEF-1:0] base,
        input int unsigned         id,
        input int unsigned         shift
    );
        return base + (XLEN_DEF'(id) << shift);
    endfunction

endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_i,
    input  logic         clr_en_i,
    input  logic [N-1:0] clr_bits_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] clr_vec;

    assign clr_vec = clr_en_i ? clr_bits_i : '0;

    // Clear wins on the write edge; a held line re-sets the bit one edge later.
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q | lines_i) & ~clr_vec;
    end

    assign pend_o = pend_q;

    // R3: without a clear, no pending bit ever falls
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_en_i |=> ($past(rst) || (($past(pend_q) & ~pend_q) == '0)));

    // R2: a high line is latched at the next edge when not cleared
    a_r2_latch: assert property (@(posedge clk) disable iff (rst)
        !clr_en_i |=> ($past(rst) || ((pend_q & $past(lines_i)) == $past(lines_i))));

endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
    import cpu_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take_i,
    input  logic    wr_en_i,
    input  logic [1:0] wr_data_i,
    input  logic    eret_i,
    output irq_en_t en_o
);
    irq_en_t en_q;
    irq_en_t en_d;

    // Priority: take, then software write, then return-from-exception.
    always_comb begin
        en_d = en_q;
        if (take_i) begin
            en_d.saved = 1'b1;
            en_d.live  = 1'b0;
        end else if (wr_en_i) begin
            en_d = irq_en_t'(wr_data_i);
        end else if (eret_i) begin
            en_d.live = en_q.saved;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    assign en_o = en_q;

    // R7 / R12: a take always leaves the saved-only pattern
    a_r7_after_take: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (en_q == 2'b10));

    // R8: return restores the live bit from the saved bit
    a_r8_eret: assert property (@(posedge clk) disable iff (rst)
        (eret_i && !take_i && !wr_en_i) |=> (en_q.live == $past(en_q.saved) && en_q.saved == $past(en_q.saved)));

endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
    import cpu_irq_pkg::*;
#(
    parameter int N          = 32,
    parameter int XLEN       = 32,
    parameter int EXC_ID     = 6,
    parameter int SLOT_SHIFT = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boundary_i,
    input  logic            en_live_i,
    input  logic [N-1:0]    pend_i,
    input  logic [N-1:0]    mask_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] pc_i,
    output logic            take_o,
    output logic            valid_o,
    output logic [XLEN-1:0] ret_pc_o,
    output logic [XLEN-1:0] target_o
);
    logic            valid_q;
    logic [XLEN-1:0] ret_q;
    logic [XLEN-1:0] tgt_q;
    logic            any_armed;

    assign any_armed = |(pend_i & mask_i);
    assign take_o    = boundary_i & en_live_i & any_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ret_q   <= '0;
            tgt_q   <= '0;
        end else begin
            valid_q <= take_o;
            if (take_o) begin
                ret_q <= pc_i;
                tgt_q <= slot_addr(base_i, EXC_ID, SLOT_SHIFT);
            end
        end
    end

    assign valid_o  = valid_q;
    assign ret_pc_o = ret_q;
    assign target_o = tgt_q;

    // R5: no redirect without a boundary in the previous cycle
    a_r5_needs_boundary: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ($past(boundary_i) && !$past(rst)));

    // R6: the redirect is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

endmodule

// File: rtl/cpu_irq_unit.sv
module cpu_irq_unit
    import cpu_irq_pkg::*;
#(
    parameter int N          = LINES_DEF,
    parameter int XLEN       = XLEN_DEF,
    parameter int EXC_ID     = 6,
    parameter int SLOT_SHIFT = 5,
    parameter int BASE_ALIGN = 8,
    parameter int RA_REG     = 30,
    parameter int REG_IDX_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         irq_lines,
    input  logic                 csr_we,
    input  logic [1:0]           csr_addr,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic [XLEN-1:0]      csr_rdata,
    input  logic                 insn_done,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic                 eret,
    output logic                 ret_we,
    output logic [REG_IDX_W-1:0] ret_reg,
    output logic [XLEN-1:0]      ret_value,
    output logic                 pc_load,
    output logic [XLEN-1:0]      pc_target
);
    localparam int BASE_HI = XLEN - BASE_ALIGN;

    csr_sel_e        sel;
    logic [N-1:0]    pend;
    logic [N-1:0]    mask_q;
    logic [BASE_HI-1:0] base_hi_q;
    logic [XLEN-1:0] base_full;
    irq_en_t         en;
    logic            take;
    logic            redir_valid;

    assign sel       = csr_sel_e'(csr_addr);
    assign base_full = {base_hi_q, {BASE_ALIGN{1'b0}}};

    irq_pending_bank #(.N(N)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .lines_i   (irq_lines),
        .clr_en_i  (csr_we && sel == SEL_PEND),
        .clr_bits_i(csr_wdata[N-1:0]),
        .pend_o    (pend)
    );

    irq_enable_ctl u_en (
        .clk      (clk),
        .rst      (rst),
        .take_i   (take),
        .wr_en_i  (csr_we && sel == SEL_ENAB),
        .wr_data_i(csr_wdata[1:0]),
        .eret_i   (eret),
        .en_o     (en)
    );

    irq_redirect #(
        .N(N), .XLEN(XLEN), .EXC_ID(EXC_ID), .SLOT_SHIFT(SLOT_SHIFT)
    ) u_redir (
        .clk       (clk),
        .rst       (rst),
        .boundary_i(insn_done),
        .en_live_i (en.live),
        .pend_i    (pend),
        .mask_i    (mask_q),
        .base_i    (base_full),
        .pc_i      (cur_pc),
        .take_o    (take),
        .valid_o   (redir_valid),
        .ret_pc_o  (ret_value),
        .target_o  (pc_target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            base_hi_q <= '0;
        end else if (csr_we) begin
            if (sel == SEL_MASK) mask_q    <= csr_wdata[N-1:0];
            if (sel == SEL_BASE) base_hi_q <= csr_wdata[XLEN-1:BASE_ALIGN];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_PEND: csr_rdata = XLEN'(pend);
            SEL_MASK: csr_rdata = XLEN'(mask_q);
            SEL_ENAB: csr_rdata = XLEN'(en);
            SEL_BASE: csr_rdata = base_full;
            default:  csr_rdata = '0;
        endcase
    end

    assign pc_load = redir_valid;
    assign ret_we  = redir_valid;
    assign ret_reg = REG_IDX_W'(RA_REG);

    // R7: a redirect is always accompanied by the saved-only enable state
    a_r7_redirect_en: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (en == 2'b10));

    // R5: a boundary with the live enable clear never redirects
    a_r5_disabled: assert property (@(posedge clk) disable iff (rst)
        (insn_done && !en.live) |=> !pc_load);

    // R1: reset leaves the state registers cleared
    a_r1_reset: assert property (@(posedge clk)
        $past(rst) |-> (pend == '0 && mask_q == '0 && en == 2'b00 && !pc_load));

endmodule

// File: tb/test_cpu_irq_unit.sv
`timescale 1ns/1ps
module test_cpu_irq_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_lines;
    logic        csr_we;
    logic [1:0]  csr_addr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        insn_done;
    logic [31:0] cur_pc;
    logic        eret;
    logic        ret_we;
    logic [4:0]  ret_reg;
    logic [31:0] ret_value;
    logic        pc_load;
    logic [31:0] pc_target;

    int checks = 0;
    int fails  = 0;

    typedef struct { logic [31:0] pc; logic [31:0] tgt; } exp_t;
    exp_t exp_q[$];
    logic [31:0] base_model;

    always #10 clk = ~clk;

    cpu_irq_unit i_cpu_irq_unit (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .insn_done(insn_done), .cur_pc(cur_pc),
        .eret(eret), .ret_we(ret_we), .ret_reg(ret_reg),
        .ret_value(ret_value), .pc_load(pc_load), .pc_target(pc_target)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        tick();
        csr_we = 1'b0;
    endtask

    task automatic csr_check(input logic [1:0] a, input logic [31:0] exp, input string req);
        csr_addr = a;
        #1;
        chk(csr_rdata === exp, req, csr_rdata, exp);
    endtask

    // Driver: present a boundary; queue the expected redirect when one should follow.
    task automatic boundary(input logic [31:0] pc, input bit expect_take, input string req);
        exp_t e;
        insn_done = 1'b1; cur_pc = pc;
        if (expect_take) begin
            e.pc = pc; e.tgt = base_model + 32'h0000_00C0;
            exp_q.push_back(e);
        end
        tick();
        insn_done = 1'b0;
        chk(pc_load === expect_take, req, 32'(pc_load), 32'(expect_take));
    endtask

    // Monitor: compare each redirect against the queue at the falling edge.
    always @(negedge clk) begin
        if (!rst && pc_load === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R5 unexpected redirect act=%h exp=none", pc_target);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(pc_target === e.tgt, "R6 handler address", pc_target, e.tgt);
                chk(ret_value === e.pc, "R6 return value", ret_value, e.pc);
                chk(ret_reg === 5'd30 && ret_we === 1'b1, "R6 return register write",
                    {26'd0, ret_we, ret_reg}, {26'd0, 1'b1, 5'd30});
            end
        end
    end

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; irq_lines = '0; csr_we = 1'b0; csr_addr = 2'd0; csr_wdata = '0;
        insn_done = 1'b0; cur_pc = '0; eret = 1'b0; base_model = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1
        csr_check(2'd0, 32'h0, "R1 pending after reset");
        csr_check(2'd1, 32'h0, "R1 mask after reset");
        csr_check(2'd2, 32'h0, "R1 enable after reset");
        chk(pc_load === 1'b0, "R1 no redirect after reset", 32'(pc_load), 32'h0);

        // R9
        csr_write(2'd3, 32'h0000_1234);
        base_model = 32'h0000_1200;
        csr_check(2'd3, 32'h0000_1200, "R9 base low bits dropped");

        // R11
        csr_write(2'd1, 32'hFFFF_0001);
        csr_check(2'd1, 32'hFFFF_0001, "R11 mask readback");

        // R2 / R3
        irq_lines = 32'h0000_0008;
        tick();
        csr_check(2'd0, 32'h0000_0008, "R2 line 3 latched");
        irq_lines = '0;
        tick(); tick();
        csr_check(2'd0, 32'h0000_0008, "R3 pending kept after line drop");

        // R5: enable clear, then masked
        boundary(32'h0000_0300, 1'b0, "R5 no take with enable clear");
        csr_write(2'd2, 32'h1);
        boundary(32'h0000_0304, 1'b0, "R5 no take when masked");
        tick();
        chk(pc_load === 1'b0, "R5 no take without boundary", 32'(pc_load), 32'h0);

        // R6 / R7
        csr_write(2'd1, 32'h0000_0008);
        boundary(32'h0000_0400, 1'b1, "R6 take at boundary");
        csr_check(2'd2, 32'h2, "R7 enable becomes 0x2");
        tick();
        chk(pc_load === 1'b0, "R6 redirect lasts one cycle", 32'(pc_load), 32'h0);
        boundary(32'h0000_0404, 1'b0, "R5 no take while in handler");

        // R8
        eret = 1'b1; tick(); eret = 1'b0;
        csr_check(2'd2, 32'h3, "R8 return restores live enable");

        // R4
        csr_write(2'd0, 32'h0000_0008);
        csr_check(2'd0, 32'h0, "R4 write-one clears pending");
        irq_lines = 32'h0000_0020;
        tick();
        csr_check(2'd0, 32'h0000_0020, "R2 line 5 latched");
        csr_write(2'd0, 32'h0000_0020);
        csr_check(2'd0, 32'h0, "R4 clear wins on write edge");
        tick();
        csr_check(2'd0, 32'h0000_0020, "R4 held line sets bit again");

        // R10
        csr_write(2'd1, 32'h0000_0020);
        boundary(32'h0000_0500, 1'b1, "R10 first take of held line");
        boundary(32'h0000_0504, 1'b0, "R5 no retake while disabled");
        csr_write(2'd2, 32'h1);
        boundary(32'h0000_0508, 1'b1, "R10 retake after re-enable");

        // R12
        csr_write(2'd2, 32'h1);
        eret = 1'b1;
        boundary(32'h0000_0600, 1'b1, "R12 take with simultaneous return");
        eret = 1'b0;
        csr_check(2'd2, 32'h2, "R12 take wins over return");

        tick(); tick();
        chk(exp_q.size() == 0, "R6 all expected redirects seen", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule